// File: doc/BRIEF.md
# Region Replay Recovery Controller

This controller steers the program counter and the retirement mode of a core that lets instructions retire out of order inside compiler-built re-executable regions. No hardware checkpoint is kept. When an instruction faults, the controller records the faulting PC and sends fetch back to the start of the current region. It then lets issue run only as far as the recorded instruction, so the region replays up to the fault and stops there. If that same instruction faults again, the architectural state is precise at that point, and software receives a trap. When the handler returns, execution resumes at the faulting instruction.

Sometimes the replay faults at a PC other than the recorded one. In that case the region is run once more with issue and retirement strictly in order, and every fault in that run traps precisely. Strict mode ends when execution passes the next region boundary. A time-critical interrupt is taken at once, and the whole region is replayed from its start after the handler returns.

The controller has four states. NORMAL is regular execution. REPLAY is the limited re-run of the region. TRAP means the controller is waiting for the handler to return. INORDER_REPLAY is the strict in-order re-run. The transitions are:
- arm: NORMAL to REPLAY.
- precise trap: REPLAY or INORDER_REPLAY to TRAP.
- urgent trap: any non-TRAP state to TRAP.
- stray fault: REPLAY to INORDER_REPLAY.
- resume: TRAP to NORMAL or to INORDER_REPLAY.
- leave: INORDER_REPLAY to NORMAL.

Top module: `region_replay_ctrl`

## Requirements
- R1: After reset the controller is in NORMAL. The `ctl_state` encoding is NORMAL=0, REPLAY=1, TRAP=2, INORDER_REPLAY=3. Reset also clears `inorder_mode`, `redirect_valid`, `trap_req`, `issue_limit_en` and `epc`.
- R2: A non-urgent fault in NORMAL is handled on the next cycle. The controller loads `epc` with the faulting PC and raises `redirect_valid` for one cycle, with `redirect_pc` equal to `region_start_pc` as sampled with the fault. It also enters REPLAY and keeps that region start for later use.
- R3: `issue_limit_en` is high exactly in REPLAY, and `issue_limit_pc` then equals `epc`. In the same cycle, `issue_stall` is high exactly when `issue_valid` is high, the state is REPLAY, and `issue_pc` is greater than `epc` as an unsigned compare. Outside REPLAY it is never high.
- R4: In REPLAY, a non-urgent fault whose PC equals `epc` produces a precise trap on the next cycle. `trap_req` pulses for one cycle, `trap_cause` takes the new cause, and the state becomes TRAP.
- R5: In TRAP, a `handler_done` for a non-urgent trap redirects to `epc` on the next cycle. The controller returns to NORMAL if the trap came from REPLAY, or to INORDER_REPLAY if it came from INORDER_REPLAY.
- R6: In REPLAY, a non-urgent fault at a PC other than `epc` redirects to the kept region start and sets `inorder_mode`. The state becomes INORDER_REPLAY, and no trap is raised.
- R7: In INORDER_REPLAY, every fault traps on the next cycle, and `epc` takes that fault's PC.
- R8: In INORDER_REPLAY, a `region_boundary` with no fault in the same cycle returns the controller to NORMAL and clears `inorder_mode`. If a fault and a boundary arrive together, the fault wins.
- R9: A fault with `exc_urgent` set, in any state other than TRAP, traps on the next cycle and loads `epc` with its PC. The matching `handler_done` then redirects to the kept region start, returns to NORMAL and clears `inorder_mode`.
- R10: In TRAP, faults and region boundaries are ignored, and `epc` does not change until `handler_done` arrives. A `handler_done` outside TRAP has no effect.
- R11: A `region_boundary` in NORMAL or in REPLAY leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | A fault or interrupt is reported this cycle |
| exc_pc | input | PC_W | PC of the faulting instruction |
| exc_cause | input | CAUSE_W | Cause code of the fault |
| exc_urgent | input | 1 | Event is a time-critical interrupt |
| region_start_pc | input | PC_W | Start PC of the current region |
| region_boundary | input | 1 | Execution passed a region boundary |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_pc | input | PC_W | PC of the offered instruction |
| handler_done | input | 1 | Software handler returned |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | PC_W | Redirect target |
| issue_limit_en | output | 1 | Issue limit is active |
| issue_limit_pc | output | PC_W | Last PC allowed to issue |
| issue_stall | output | 1 | Offered instruction lies past the limit |
| trap_req | output | 1 | One-cycle precise trap request |
| trap_cause | output | CAUSE_W | Cause of the latest trap |
| epc | output | PC_W | Saved exception PC |
| inorder_mode | output | 1 | Strict in-order issue and retirement |
| ctl_state | output | 2 | Controller state |

## Verification
A reference model in the bench is driven by random events and runs for thousands of cycles. Faulting PCs are biased so that about a quarter of them hit the saved PC. This separates the precise-trap path in REPLAY from the stray-fault path into strict mode. Urgent events are mixed into every state, which checks that replay-from-start is kept apart from resume-at-`epc`. Directed sequences cover the remaining cases. The issue limit is tested with PCs just below, equal to and just above the limit, which exposes off-by-one errors and signed-versus-unsigned compare errors. Other directed cases send boundaries and handler returns to states that must ignore them, and send a fault and a boundary together in strict mode.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int ST_W  = 2;
    localparam int ACT_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_NORMAL         = 2'd0,
        ST_REPLAY         = 2'd1,
        ST_TRAP           = 2'd2,
        ST_INORDER_REPLAY = 2'd3
    } rrc_state_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE          = 4'd0,
        ACT_ARM_REPLAY    = 4'd1,
        ACT_TRAP_PRECISE  = 4'd2,
        ACT_TRAP_STRICT   = 4'd3,
        ACT_TRAP_URGENT   = 4'd4,
        ACT_GO_STRICT     = 4'd5,
        ACT_RESUME_EPC    = 4'd6,
        ACT_RESUME_REGION = 4'd7,
        ACT_LEAVE_STRICT  = 4'd8
    } rrc_act_e;

endpackage

// File: rtl/rrc_issue_gate.sv
module rrc_issue_gate #(
    parameter int PC_W = 32
) (
    input  logic            limit_en,
    input  logic [PC_W-1:0] limit_pc,
    input  logic            issue_valid,
    input  logic [PC_W-1:0] issue_pc,
    output logic            issue_stall
);

    logic past_limit;

    always_comb begin
        past_limit  = (issue_pc > limit_pc);
        issue_stall = limit_en & issue_valid & past_limit;
    end

endmodule

// File: rtl/rrc_fsm.sv
module rrc_fsm
    import rrc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_valid,
    input  logic            exc_urgent,
    input  logic [PC_W-1:0] exc_pc,
    input  logic [PC_W-1:0] saved_pc,
    input  logic            region_boundary,
    input  logic            handler_done,
    input  logic            trap_was_urgent,
    input  logic            trap_was_strict,
    output rrc_state_e      state_q,
    output rrc_act_e        act,
    output logic            cap_region
);

    rrc_state_e state_d;

    // next state and action
    always_comb begin
        state_d    = state_q;
        act        = ACT_NONE;
        cap_region = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (exc_valid) begin
                    cap_region = 1'b1;
                    if (exc_urgent) begin
                        state_d = ST_TRAP;
                        act     = ACT_TRAP_URGENT;
                    end else begin
                        state_d = ST_REPLAY;
                        act     = ACT_ARM_REPLAY;
                    end
                end
            end
            ST_REPLAY: begin
                if (exc_valid) begin
                    if (exc_urgent) begin
                        state_d = ST_TRAP;
                        act     = ACT_TRAP_URGENT;
                    end else if (exc_pc == saved_pc) begin
                        state_d = ST_TRAP;
                        act     = ACT_TRAP_PRECISE;
                    end else begin
                        state_d = ST_INORDER_REPLAY;
                        act     = ACT_GO_STRICT;
                    end
                end
            end
            ST_TRAP: begin
                if (handler_done) begin
                    if (trap_was_urgent) begin
                        state_d = ST_NORMAL;
                        act     = ACT_RESUME_REGION;
                    end else if (trap_was_strict) begin
                        state_d = ST_INORDER_REPLAY;
                        act     = ACT_RESUME_EPC;
                    end else begin
                        state_d = ST_NORMAL;
                        act     = ACT_RESUME_EPC;
                    end
                end
            end
            ST_INORDER_REPLAY: begin
                if (exc_valid) begin
                    state_d = ST_TRAP;
                    act     = exc_urgent ? ACT_TRAP_URGENT : ACT_TRAP_STRICT;
                end else if (region_boundary) begin
                    state_d = ST_NORMAL;
                    act     = ACT_LEAVE_STRICT;
                end
            end
            default: begin
                state_d = ST_NORMAL;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/rrc_ctx_regs.sv
module rrc_ctx_regs
    import rrc_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rrc_act_e           act,
    input  logic               cap_region,
    input  logic [PC_W-1:0]    exc_pc,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [PC_W-1:0]    region_start_pc,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [PC_W-1:0]    epc_q,
    output logic               inorder_q,
    output logic               trap_was_urgent,
    output logic               trap_was_strict
);

    logic [PC_W-1:0] region_q;

    // output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_valid  <= 1'b0;
            redirect_pc     <= '0;
            trap_req        <= 1'b0;
            trap_cause      <= '0;
            epc_q           <= '0;
            inorder_q       <= 1'b0;
            trap_was_urgent <= 1'b0;
            trap_was_strict <= 1'b0;
            region_q        <= '0;
        end else begin
            redirect_valid <= 1'b0;
            trap_req       <= 1'b0;
            if (cap_region) region_q <= region_start_pc;
            unique case (act)
                ACT_ARM_REPLAY: begin
                    epc_q          <= exc_pc;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= region_start_pc;
                end
                ACT_TRAP_PRECISE, ACT_TRAP_STRICT, ACT_TRAP_URGENT: begin
                    epc_q           <= exc_pc;
                    trap_cause      <= exc_cause;
                    trap_req        <= 1'b1;
                    trap_was_urgent <= (act == ACT_TRAP_URGENT);
                    trap_was_strict <= (act == ACT_TRAP_STRICT);
                end
                ACT_GO_STRICT: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= region_q;
                    inorder_q      <= 1'b1;
                end
                ACT_RESUME_EPC: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= epc_q;
                    inorder_q      <= trap_was_strict;
                end
                ACT_RESUME_REGION: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= region_q;
                    inorder_q      <= 1'b0;
                end
                ACT_LEAVE_STRICT: begin
                    inorder_q <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    AST_RESUME_AT_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RESUME_EPC) |=> (redirect_valid && redirect_pc == $past(epc_q))); // R5

endmodule

// File: rtl/region_replay_ctrl.sv
module region_replay_ctrl
    import rrc_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [PC_W-1:0]    exc_pc,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_urgent,
    input  logic [PC_W-1:0]    region_start_pc,
    input  logic               region_boundary,
    input  logic               issue_valid,
    input  logic [PC_W-1:0]    issue_pc,
    input  logic               handler_done,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic               issue_limit_en,
    output logic [PC_W-1:0]    issue_limit_pc,
    output logic               issue_stall,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [PC_W-1:0]    epc,
    output logic               inorder_mode,
    output logic [ST_W-1:0]    ctl_state
);

    rrc_state_e state_q;
    rrc_act_e   act;
    logic       cap_region;
    logic       trap_was_urgent;
    logic       trap_was_strict;

    rrc_fsm #(.PC_W(PC_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .exc_valid       (exc_valid),
        .exc_urgent      (exc_urgent),
        .exc_pc          (exc_pc),
        .saved_pc        (epc),
        .region_boundary (region_boundary),
        .handler_done    (handler_done),
        .trap_was_urgent (trap_was_urgent),
        .trap_was_strict (trap_was_strict),
        .state_q         (state_q),
        .act             (act),
        .cap_region      (cap_region)
    );

    rrc_ctx_regs #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .act             (act),
        .cap_region      (cap_region),
        .exc_pc          (exc_pc),
        .exc_cause       (exc_cause),
        .region_start_pc (region_start_pc),
        .redirect_valid  (redirect_valid),
        .redirect_pc     (redirect_pc),
        .trap_req        (trap_req),
        .trap_cause      (trap_cause),
        .epc_q           (epc),
        .inorder_q       (inorder_mode),
        .trap_was_urgent (trap_was_urgent),
        .trap_was_strict (trap_was_strict)
    );

    always_comb begin
        issue_limit_en = (state_q == ST_REPLAY);
        issue_limit_pc = epc;
        ctl_state      = state_q;
    end

    rrc_issue_gate #(.PC_W(PC_W)) u_gate (
        .limit_en    (issue_limit_en),
        .limit_pc    (issue_limit_pc),
        .issue_valid (issue_valid),
        .issue_pc    (issue_pc),
        .issue_stall (issue_stall)
    );

    AST_FIRST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && exc_valid && !exc_urgent) |=>
        (redirect_valid && redirect_pc == $past(region_start_pc) &&
         epc == $past(exc_pc) && state_q == ST_REPLAY)); // R2

    AST_STALL_ONLY_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> (state_q == ST_REPLAY && issue_valid)); // R3

    AST_SAME_PC_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY && exc_valid && !exc_urgent && exc_pc == epc) |=>
        (trap_req && state_q == ST_TRAP && trap_cause == $past(exc_cause))); // R4

    AST_TRAP_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (state_q == ST_TRAP)); // R4

    AST_STRAY_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY && exc_valid && !exc_urgent && exc_pc != epc) |=>
        (inorder_mode && redirect_valid && !trap_req)); // R6

    AST_STRICT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INORDER_REPLAY && exc_valid) |=>
        (trap_req && epc == $past(exc_pc))); // R7

    AST_LEAVE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INORDER_REPLAY && !exc_valid && region_boundary) |=>
        (state_q == ST_NORMAL && !inorder_mode)); // R8

    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP && !handler_done) |=>
        (state_q == ST_TRAP && !redirect_valid && $stable(epc))); // R10

endmodule

// File: tb/test_region_replay_ctrl.sv
module test_region_replay_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int CAUSE_W    = 5;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               exc_valid, exc_urgent, region_boundary, issue_valid, handler_done;
    logic [PC_W-1:0]    exc_pc, region_start_pc, issue_pc;
    logic [CAUSE_W-1:0] exc_cause;
    logic               redirect_valid, issue_limit_en, issue_stall, trap_req, inorder_mode;
    logic [PC_W-1:0]    redirect_pc, issue_limit_pc, epc;
    logic [CAUSE_W-1:0] trap_cause;
    logic [1:0]         ctl_state;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference model
    int                 m_st;
    logic [PC_W-1:0]    m_epc, m_rs, m_redpc;
    logic [CAUSE_W-1:0] m_cause;
    logic               m_urg, m_fin, m_redv, m_trap, m_inord;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_replay_ctrl #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) i_region_replay_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_pc(exc_pc),
        .exc_cause(exc_cause), .exc_urgent(exc_urgent),
        .region_start_pc(region_start_pc), .region_boundary(region_boundary),
        .issue_valid(issue_valid), .issue_pc(issue_pc), .handler_done(handler_done),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .issue_limit_en(issue_limit_en), .issue_limit_pc(issue_limit_pc),
        .issue_stall(issue_stall), .trap_req(trap_req), .trap_cause(trap_cause),
        .epc(epc), .inorder_mode(inorder_mode), .ctl_state(ctl_state)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_epc = '0; m_rs = '0; m_redpc = '0; m_cause = '0;
        m_urg = 0; m_fin = 0; m_redv = 0; m_trap = 0; m_inord = 0;
    endtask

    task automatic model_trap(input logic urg, input logic fin);
        m_epc = exc_pc; m_cause = exc_cause; m_trap = 1;
        m_urg = urg; m_fin = fin; m_st = 2;
    endtask

    task automatic model_step();
        m_redv = 0; m_trap = 0;
        case (m_st)
            0: if (exc_valid) begin
                m_rs = region_start_pc;
                if (exc_urgent) model_trap(1, 0);
                else begin
                    m_epc = exc_pc; m_redv = 1; m_redpc = region_start_pc; m_st = 1;
                end
            end
            1: if (exc_valid) begin
                if (exc_urgent) model_trap(1, 0);
                else if (exc_pc == m_epc) model_trap(0, 0);
                else begin
                    m_redv = 1; m_redpc = m_rs; m_inord = 1; m_st = 3;
                end
            end
            2: if (handler_done) begin
                m_redv = 1;
                if (m_urg) begin
                    m_redpc = m_rs; m_inord = 0; m_st = 0;
                end else begin
                    m_redpc = m_epc; m_inord = m_fin; m_st = m_fin ? 3 : 0;
                end
            end
            default: if (exc_valid) model_trap(exc_urgent, !exc_urgent);
                     else if (region_boundary) begin
                         m_st = 0; m_inord = 0;
                     end
        endcase
    endtask

    task automatic compare_all();
        chk("R2 redirect_valid", redirect_valid, m_redv);
        if (m_redv) chk("R2 redirect_pc", redirect_pc, m_redpc);
        chk("R4 trap_req", trap_req, m_trap);
        chk("R4 trap_cause", trap_cause, m_cause);
        chk("R7 epc", epc, m_epc);
        chk("R6 inorder_mode", inorder_mode, m_inord);
        chk("R5 ctl_state", ctl_state, m_st);
        chk("R3 issue_limit_en", issue_limit_en, m_st == 1);
        if (m_st == 1) chk("R3 issue_limit_pc", issue_limit_pc, m_epc);
    endtask

    task automatic drive(input logic ev, input logic [PC_W-1:0] pc, input logic [CAUSE_W-1:0] c,
                         input logic urg, input logic [PC_W-1:0] rs, input logic bnd,
                         input logic iv, input logic [PC_W-1:0] ipc, input logic hd);
        exc_valid = ev; exc_pc = pc; exc_cause = c; exc_urgent = urg;
        region_start_pc = rs; region_boundary = bnd; issue_valid = iv;
        issue_pc = ipc; handler_done = hd;
    endtask

    task automatic step();
        #1;
        chk("R3 issue_stall", issue_stall, issue_valid && m_st == 1 && issue_pc > m_epc);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 32'h0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0;
        idle();
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctl_state", ctl_state, 0);
        chk("R1 inorder_mode", inorder_mode, 0);
        chk("R1 redirect_valid", redirect_valid, 0);
        chk("R1 trap_req", trap_req, 0);
        chk("R1 issue_limit_en", issue_limit_en, 0);
        chk("R1 epc", epc, 0);
        rst_n = 1;
        idle(); step();

        // arm, limit, precise trap, resume
        drive(1, 32'h100, 5'd3, 0, 32'hF0, 0, 0, 0, 0); step();
        chk("R2 redirect_pc", redirect_pc, 32'hF0);
        chk("R2 epc", epc, 32'h100);
        drive(0, 0, 0, 0, 32'hF0, 1, 1, 32'h104, 0); #1;
        chk("R3 stall above limit", issue_stall, 1);
        step();
        chk("R11 boundary in REPLAY", ctl_state, 1);
        drive(0, 0, 0, 0, 32'hF0, 0, 1, 32'h100, 0); #1;
        chk("R3 no stall at limit", issue_stall, 0);
        step();
        drive(0, 0, 0, 0, 32'hF0, 0, 1, 32'hFC, 0); step();
        drive(1, 32'h100, 5'd7, 0, 32'hF0, 0, 0, 0, 0); step();
        chk("R4 trap cause", trap_cause, 7);
        chk("R4 trap state", ctl_state, 2);
        drive(1, 32'h200, 5'd9, 0, 32'hF0, 1, 0, 0, 0); step();
        chk("R10 epc held in TRAP", epc, 32'h100);
        chk("R10 no redirect in TRAP", redirect_valid, 0);
        chk("R4 trap pulse", trap_req, 0);
        drive(0, 0, 0, 0, 32'hF0, 0, 0, 0, 1); step();
        chk("R5 resume at epc", redirect_pc, 32'h100);
        chk("R5 back to NORMAL", ctl_state, 0);
        idle(); step();

        // stray fault, strict mode
        drive(1, 32'h140, 5'd1, 0, 32'h120, 0, 0, 0, 0); step();
        drive(1, 32'h130, 5'd2, 0, 32'h999, 0, 0, 0, 0); step();
        chk("R6 redirect to kept start", redirect_pc, 32'h120);
        chk("R6 strict state", ctl_state, 3);
        chk("R6 no trap", trap_req, 0);
        drive(1, 32'h128, 5'd4, 0, 32'h120, 1, 0, 0, 0); step();
        chk("R7 strict trap", trap_req, 1);
        chk("R8 fault wins over boundary", ctl_state, 2);
        chk("R7 epc", epc, 32'h128);
        drive(0, 0, 0, 0, 32'h120, 0, 0, 0, 1); step();
        chk("R5 resume to strict", ctl_state, 3);
        chk("R5 inorder kept", inorder_mode, 1);
        drive(0, 0, 0, 0, 32'h120, 1, 0, 0, 0); step();
        chk("R8 leave strict", ctl_state, 0);
        chk("R8 inorder cleared", inorder_mode, 0);
        drive(0, 0, 0, 0, 32'h120, 1, 0, 0, 1); step();
        chk("R10 handler_done in NORMAL", redirect_valid, 0);
        chk("R11 boundary in NORMAL", ctl_state, 0);

        // urgent interrupt
        drive(1, 32'h300, 5'd11, 1, 32'h2F0, 0, 0, 0, 0); step();
        chk("R9 urgent trap", trap_req, 1);
        chk("R9 urgent epc", epc, 32'h300);
        drive(0, 0, 0, 0, 32'h2F0, 0, 0, 0, 1); step();
        chk("R9 replay from region start", redirect_pc, 32'h2F0);
        chk("R9 back to NORMAL", ctl_state, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [PC_W-1:0] pc;
            pc = ($urandom % 4 == 0) ? m_epc : 32'h1000 + (($urandom % 64) << 2);
            drive(($urandom % 4) == 0, pc, 5'($urandom), ($urandom % 8) == 0,
                  32'h1000 + (($urandom % 16) << 2), ($urandom % 5) == 0,
                  ($urandom % 2) == 0, 32'h1000 + (($urandom % 64) << 2),
                  ($urandom % 3) == 0);
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule